// File: doc/BRIEF.md
# Element-Pointer Short Load/Store Unit

This unit serves the compact memory accesses of a processor core that address data relative to one dedicated base register, the element pointer. Each request names an access size (byte, halfword or word), a direction (load or store), a signedness choice for loads and a short unsigned displacement. The unit forms the effective address, derives the byte enables for a 32-bit little-endian memory port, steers store data into the addressed lanes and, for loads, turns the returned memory word into a sign- or zero-extended register result.

The displacement is never sign-extended. The number of displacement bits that count depends on the kind of access, and the unit discards the rest. The core holds a request on the request side until the memory port accepts it. Request and memory handshakes are wired straight through, so a load whose memory answers at once delivers its result one clock after it is issued.

Top module: `ep_ldst_unit`

## Requirements
- R1: The memory address is `ep_base` plus the kept displacement bits, zero-extended to 32 bits, with modulo-2^32 wrap. The displacement offset is therefore never above 255.
- R2: Only the low bits of `req_disp` count, and the rest are ignored. A signed byte load keeps 7 bits and an unsigned byte load keeps 4. A signed halfword load keeps 8 and an unsigned halfword load keeps 5. A word access keeps 8, a byte store 7 and a halfword store 8. `req_unsigned` has no effect on stores or on word loads.
- R3: For halfword accesses bit 0 of the kept displacement is forced to 0. For word accesses bits 1:0 are forced to 0.
- R4: `req_size` encoding: 00 is byte, 01 is halfword, 10 and 11 are word. `mem_be` bit i enables byte lane i (bits 8i+7:8i). A byte access enables lane `mem_addr[1:0]`. A halfword access enables lanes 1:0 when `mem_addr[1]` is 0 and lanes 3:2 when it is 1. A word access enables all four lanes.
- R5: A signed byte load returns the addressed byte of `mem_rdata`, sign-extended to 32 bits.
- R6: An unsigned byte or halfword load returns the addressed byte or halfword (lanes as in R4), zero-extended to 32 bits.
- R7: A signed halfword load returns the addressed halfword of `mem_rdata`, sign-extended to 32 bits.
- R8: A word load returns `mem_rdata` unchanged.
- R9: A store drives `mem_we`=1. It places the low byte, the low halfword or the whole word of `req_wdata` into the enabled lanes and drives zero in the other lanes. A store never raises `rsp_valid`.
- R10: `mem_valid` follows `req_valid` and `req_ready` follows `mem_ready`. A load accepted in a cycle where `req_valid` and `mem_ready` are both 1 raises `rsp_valid` for exactly the next cycle, with `rsp_data` built from that cycle's `mem_rdata`. While `mem_ready` is 0, no response appears.
- R11: While `rst` is high, `rsp_valid` and `rsp_data` are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (see R4) |
| req_unsigned | input | 1 | Load zero-extends when 1 |
| req_disp | input | 8 | Raw displacement field |
| ep_base | input | 32 | Element-pointer register value |
| req_wdata | input | 32 | Store source register |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts; read data valid this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Memory read word |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Extended load result |

## Verification
The address, byte enables, write enable and steered store data follow the request in the same cycle. The bench drives each request just after a falling edge and samples these outputs one nanosecond later, before the next rising edge. The load result passes through one register, so it is due one rising edge after the cycle in which `req_valid` and `mem_ready` are both high. The bench reads it at the falling edge that follows that rising edge and checks that it has gone again one cycle later. With wait states it confirms that no result appears in any cycle where the memory has not yet accepted the request.

// File: rtl/ep_ldst_pkg.sv
package ep_ldst_pkg;

    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / 8;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int DISP_W     = 8;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } acc_size_e;

    typedef struct packed {
        acc_size_e size;
        logic      is_unsigned;
        logic      is_store;
    } acc_mode_t;

    // Count of displacement bits that take part in the address, per access kind.
    function automatic logic [3:0] disp_bits(acc_mode_t m);
        logic [3:0] w;
        if (m.size[1]) begin
            w = 4'd8;
        end else if (m.size == SZ_HALF) begin
            w = (m.is_unsigned && !m.is_store) ? 4'd5 : 4'd8;
        end else begin
            w = (m.is_unsigned && !m.is_store) ? 4'd4 : 4'd7;
        end
        return w;
    endfunction

    // Mask of displacement bits kept after width limiting and alignment forcing.
    function automatic logic [DISP_W-1:0] disp_keep(acc_mode_t m);
        logic [DISP_W-1:0] mask;
        mask = {DISP_W{1'b1}} >> (4'(DISP_W) - disp_bits(m));
        if (m.size == SZ_HALF) mask[0] = 1'b0;
        if (m.size[1])         mask[1:0] = 2'b00;
        return mask;
    endfunction

endpackage

// File: rtl/ep_addr_gen.sv
module ep_addr_gen
    import ep_ldst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp_raw,
    input  acc_mode_t         mode,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - DISP_W;

    logic [DISP_W-1:0] disp_kept;

    always_comb begin
        disp_kept = disp_raw & disp_keep(mode);
        addr      = base + {{PAD_W{1'b0}}, disp_kept};
    end
endmodule

// File: rtl/ep_lane_ctl.sv
module ep_lane_ctl
    import ep_ldst_pkg::*;
(
    input  logic [LANE_IDX_W-1:0] addr_lo,
    input  acc_size_e             size,
    input  logic [DATA_W-1:0]     src,
    output logic [LANES-1:0]      be,
    output logic [DATA_W-1:0]     lanes_out
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LANE_IDX_W-1:0] IDX = LANE_IDX_W'(i);
        logic       hit_byte;
        logic       hit_half;
        logic [7:0] src_byte;

        assign hit_byte = (size == SZ_BYTE) && (addr_lo == IDX);
        assign hit_half = (size == SZ_HALF) &&
                          (addr_lo[LANE_IDX_W-1:1] == IDX[LANE_IDX_W-1:1]);
        assign be[i]    = size[1] | hit_byte | hit_half;

        assign src_byte = size[1]           ? src[8*i +: 8] :
                          (size == SZ_HALF) ? src[8*(i%2) +: 8] :
                                              src[7:0];

        assign lanes_out[8*i +: 8] = be[i] ? src_byte : 8'h00;
    end
endmodule

// File: rtl/ep_load_fmt.sv
module ep_load_fmt
    import ep_ldst_pkg::*;
(
    input  logic [DATA_W-1:0]     raw,
    input  logic [LANE_IDX_W-1:0] addr_lo,
    input  acc_mode_t             mode,
    output logic [DATA_W-1:0]     result
);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b = raw[8*addr_lo +: 8];
        sel_h = raw[16*addr_lo[LANE_IDX_W-1] +: 16];
        if (mode.size[1]) begin
            result = raw;
        end else if (mode.size == SZ_HALF) begin
            result = mode.is_unsigned ? {{(DATA_W-16){1'b0}}, sel_h}
                                      : {{(DATA_W-16){sel_h[15]}}, sel_h};
        end else begin
            result = mode.is_unsigned ? {{(DATA_W-8){1'b0}}, sel_b}
                                      : {{(DATA_W-8){sel_b[7]}}, sel_b};
        end
    end
endmodule

// File: rtl/ep_ldst_unit.sv
module ep_ldst_unit
    import ep_ldst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [ADDR_W-1:0] ep_base,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    acc_mode_t         mode;
    logic              fire_load;
    logic [DATA_W-1:0] load_word;

    always_comb begin
        mode.size        = acc_size_e'(req_size);
        mode.is_unsigned = req_unsigned;
        mode.is_store    = req_store;
    end

    assign mem_valid = req_valid;
    assign req_ready = mem_ready;
    assign mem_we    = req_store;
    assign fire_load = req_valid && mem_ready && !req_store;

    ep_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .base     (ep_base),
        .disp_raw (req_disp),
        .mode     (mode),
        .addr     (mem_addr)
    );

    ep_lane_ctl u_lanes (
        .addr_lo   (mem_addr[LANE_IDX_W-1:0]),
        .size      (mode.size),
        .src       (req_wdata),
        .be        (mem_be),
        .lanes_out (mem_wdata)
    );

    ep_load_fmt u_fmt (
        .raw     (mem_rdata),
        .addr_lo (mem_addr[LANE_IDX_W-1:0]),
        .mode    (mode),
        .result  (load_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= fire_load;
            if (fire_load) rsp_data <= load_word;
        end
    end
endmodule

// File: rtl/ep_ldst_checker.sv
module ep_ldst_checker
    import ep_ldst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic              req_unsigned,
    input logic [ADDR_W-1:0] ep_base,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_be,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data
);
    logic [ADDR_W-1:0] offs;
    logic [DATA_W-1:0] be_bits;
    logic              acc_fire;

    assign offs     = mem_addr - ep_base;
    assign acc_fire = req_valid && mem_ready;

    always_comb begin
        for (int i = 0; i < LANES; i++) be_bits[8*i +: 8] = {8{mem_be[i]}};
    end

    assert_offset_range_R1: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> offs < ADDR_W'(256));

    assert_word_align_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && req_size[1]) |-> offs[1:0] == 2'b00);

    assert_half_align_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && req_size == 2'b01) |-> offs[0] == 1'b0);

    assert_byte_be_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && req_size == 2'b00) |-> $countones(mem_be) == 1);

    assert_half_be_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && req_size == 2'b01) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

    assert_word_be_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && req_size[1]) |-> mem_be == 4'b1111);

    assert_zext_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_fire && !req_store && req_unsigned && req_size == 2'b00)
        |=> rsp_data[DATA_W-1:8] == '0);

    assert_store_lanes_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && req_store) |-> (mem_wdata & ~be_bits) == '0);

    assert_no_store_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_fire && req_store) |=> !rsp_valid);

    assert_rsp_after_load_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc_fire && !req_store));
endmodule

bind ep_ldst_unit ep_ldst_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_size     (req_size),
    .req_unsigned (req_unsigned),
    .ep_base      (ep_base),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data)
);

// File: tb/ep_ldst_unit_tb.sv
module ep_ldst_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_store, req_unsigned;
    logic [1:0]  req_size;
    logic [7:0]  req_disp;
    logic [31:0] ep_base, req_wdata;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ep_ldst_unit u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_disp(req_disp),
        .ep_base(ep_base), .req_wdata(req_wdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model drawn from the requirements.
    function automatic logic [7:0] m_disp(input logic [1:0] sz, input bit uns,
                                          input bit st, input logic [7:0] d);
        case (sz)
            2'b00:   return (uns && !st) ? (d & 8'h0F) : (d & 8'h7F);
            2'b01:   return (uns && !st) ? (d & 8'h1E) : (d & 8'hFE);
            default: return d & 8'hFC;
        endcase
    endfunction

    function automatic logic [3:0] m_be(input logic [1:0] sz, input logic [31:0] a);
        case (sz)
            2'b00:   return 4'b0001 << a[1:0];
            2'b01:   return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] m_load(input logic [1:0] sz, input bit uns,
                                           input logic [31:0] a, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        b = w >> (8 * a[1:0]);
        h = a[1] ? w[31:16] : w[15:0];
        case (sz)
            2'b00:   return uns ? {24'h0, b} : {{24{b[7]}}, b};
            2'b01:   return uns ? {16'h0, h} : {{16{h[15]}}, h};
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] m_store(input logic [1:0] sz, input logic [31:0] a,
                                            input logic [31:0] s);
        case (sz)
            2'b00:   return {24'h0, s[7:0]} << (8 * a[1:0]);
            2'b01:   return a[1] ? {s[15:0], 16'h0} : {16'h0, s[15:0]};
            default: return s;
        endcase
    endfunction

    task automatic idle();
        req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
        req_disp = 0; ep_base = 0; req_wdata = 0; mem_ready = 0; mem_rdata = 0;
    endtask

    // One access with `waits` cycles of mem_ready low before acceptance.
    task automatic access(input string tag, input bit st, input logic [1:0] sz,
                          input bit uns, input logic [7:0] d, input logic [31:0] ep,
                          input logic [31:0] src, input logic [31:0] rd, input int waits);
        logic [31:0] ea;
        ea = ep + {24'h0, m_disp(sz, uns, st, d)};
        @(negedge clk);
        req_valid = 1; req_store = st; req_size = sz; req_unsigned = uns;
        req_disp = d; ep_base = ep; req_wdata = src; mem_rdata = rd; mem_ready = 0;
        for (int k = 0; k < waits; k++) begin
            #1;
            check(mem_valid == 1'b1 && req_ready == 1'b0, {tag, " R10 wait handshake"},
                  {30'h0, mem_valid, req_ready}, 32'h2);
            @(negedge clk);
            check(rsp_valid == 1'b0, {tag, " R10 no rsp while waiting"},
                  {31'h0, rsp_valid}, 32'h0);
        end
        mem_ready = 1;
        #1;
        check(mem_addr == ea, {tag, " R1/R2/R3 address"}, mem_addr, ea);
        check(mem_be == m_be(sz, ea), {tag, " R4 byte enables"},
              {28'h0, mem_be}, {28'h0, m_be(sz, ea)});
        check(mem_we == st && req_ready, {tag, " R9/R10 we and ready"},
              {30'h0, mem_we, req_ready}, {30'h0, st, 1'b1});
        if (st)
            check(mem_wdata == m_store(sz, ea, src), {tag, " R9 store lanes"},
                  mem_wdata, m_store(sz, ea, src));
        @(negedge clk);
        idle();
        if (st) begin
            check(rsp_valid == 1'b0, {tag, " R9 store gives no rsp"},
                  {31'h0, rsp_valid}, 32'h0);
        end else begin
            check(rsp_valid == 1'b1, {tag, " R10 rsp one cycle later"},
                  {31'h0, rsp_valid}, 32'h1);
            check(rsp_data == m_load(sz, uns, ea, rd), {tag, " R5-R8 load data"},
                  rsp_data, m_load(sz, uns, ea, rd));
        end
        @(negedge clk);
        check(rsp_valid == 1'b0, {tag, " R10 rsp lasts one cycle"},
              {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_reset();
        rst = 1; idle();
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_data == 32'h0, "R11 reset state",
              rsp_data, 32'h0);
        rst = 0;
    endtask

    task automatic t_signed_byte();   // R5, R2 (7 bits)
        access("R5 lb", 0, 2'b00, 0, 8'hFF, 32'h1000_0000, 0, 32'h85_00_00_00, 0);
        access("R5 lb pos", 0, 2'b00, 0, 8'h01, 32'h0000_0003, 0, 32'hAA_BB_CC_7E, 0);
    endtask

    task automatic t_unsigned();      // R6, R2 (4 and 5 bits)
        access("R6 lbu", 0, 2'b00, 1, 8'hFF, 32'h1000_0000, 0, 32'hF0_00_00_00, 0);
        access("R6 lhu", 0, 2'b01, 1, 8'hFF, 32'h0000_0020, 0, 32'h9234_5678, 0);
    endtask

    task automatic t_signed_half();   // R7, R3
        access("R7 lh", 0, 2'b01, 0, 8'hFF, 32'h0000_0020, 0, 32'h8001_1234, 0);
        access("R7 lh low", 0, 2'b01, 0, 8'h10, 32'h0000_0020, 0, 32'h1234_C001, 0);
    endtask

    task automatic t_word();          // R8, R3, R1 wrap, R2 unsigned ignored
        access("R8 lw", 0, 2'b10, 0, 8'hFF, 32'h0000_4000, 0, 32'hDEAD_BEEF, 0);
        access("R8 lw alt", 0, 2'b11, 1, 8'h23, 32'hFFFF_FFF0, 0, 32'h8000_0001, 0);
    endtask

    task automatic t_stores();        // R9, R2 unsigned ignored on stores
        access("R9 sb", 1, 2'b00, 1, 8'hFE, 32'h0000_0100, 32'h1122_33A5, 0, 0);
        access("R9 sh", 1, 2'b01, 1, 8'hFF, 32'h0000_0100, 32'h1122_B344, 0, 0);
        access("R9 sw", 1, 2'b10, 0, 8'hFF, 32'h0000_0100, 32'hCAFE_F00D, 0, 0);
    endtask

    task automatic t_wait_states();   // R10
        access("R10 wait lb", 0, 2'b00, 0, 8'h02, 32'h0000_0200, 0, 32'h00_80_00_00, 2);
        access("R10 wait sw", 1, 2'b10, 0, 8'h04, 32'h0000_0200, 32'h0BAD_CAFE, 0, 3);
    endtask

    initial begin
        t_reset();
        t_signed_byte();
        t_unsigned();
        t_signed_half();
        t_word();
        t_stores();
        t_wait_states();
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #40000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule